// File: doc/BRIEF.md
# 100 Mb/s Transmit Line Coder

This block sits between a MAC's four-bit transmit interface and the line driver of a 100 Mb/s twisted-pair port. It runs on a 125 MHz bit clock, divides it by five to make the 25 MHz nibble clock the MAC uses, and samples one nibble plus an enable at every rising edge of that nibble clock. Each sampled slot becomes a five-bit code group. While no frame is in flight the code group is idle. When a frame starts, its first two nibbles (the first preamble octet) are replaced by a start delimiter pair. Every later nibble is translated through the 4B/5B table. When the enable falls, an end delimiter pair closes the stream.

The code groups are shifted out one bit per bit clock, most significant bit first. Each bit is XORed with a free-running eleven-stage scrambler key. The scrambled bit then drives a three-level MLT3 state machine. The result is a two-bit encoding of the line level, meant for a differential driver outside this block.

Top module: `fx_tx_coder`

## Requirements
- R1: `tx_clk` is the bit clock divided by five: high for two bit cycles, then low for three. It is high during reset. Inputs are sampled at the bit-clock edge where `tx_clk` rises.
- R2: A slot sampled with `tx_en` high while no stream is active produces J=11000. The following slot produces K=10001. The nibbles sampled in those two slots are discarded.
- R3: Later slots sampled with `tx_en` high carry the nibble's 4B/5B group (nibble:group): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R4: The first slot after the K slot that is sampled with `tx_en` low produces T=01101. The slot after it produces R=00111, and the stream then ends.
- R5: When no stream is active and `tx_en` is low, the group is idle, 11111. The first slot after reset is idle.
- R6: Groups are serialized MSB first, one bit per bit clock. Each bit is XORed with a key from an LFSR for x^11+x^9+1: key = s[10]^s[8], and the state shifts left taking in the key. The state starts from `SEED` at reset, advances on every bit clock, and is never all-zero. Bit n since reset decides the line level seen after edge n.
- R7: The line level is encoded as 00=0, 01=+1, 11=-1, and 10 never appears. It starts at 0. On a scrambled 1 it steps through the cycle 0,+1,0,-1, and on a 0 it holds.
- R8: `tx_en` is ignored in the K slot and in the R slot. Dropping `tx_en` during K still yields K, and raising it during R still yields R.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Frame enable from the MAC |
| txd | input | 4 | Transmit nibble from the MAC |
| tx_clk | output | 1 | 25 MHz nibble clock (bit clock / 5) |
| line_lvl | output | 2 | Encoded MLT3 line level |

## Verification
The bench builds the coder with `SEED` = 11'h5A3 rather than the all-ones default. The key sequence therefore starts from an asymmetric state, so a shifted tap or a wrong start state cannot go unnoticed. The bench's own descrambler, which starts from the same seed, recovers every code group from the line transitions alone. That brings delimiter placement, table lookup and bit order within reach of a per-slot comparison. Directed cases drop the enable inside the K slot and raise it inside the R slot, and random frames with short gaps fill in the rest.

// File: rtl/fxc_pkg.sv
`timescale 1ns/1ps
package fxc_pkg;
    localparam int GRP_W      = 5;
    localparam int CNT_W      = $clog2(GRP_W);
    localparam int TXCLK_HI   = 2;
    localparam int SCR_W      = 11;
    localparam int SCR_TAP_A  = SCR_W - 1;
    localparam int SCR_TAP_B  = 8;

    typedef logic [GRP_W-1:0] grp_t;

    localparam grp_t GRP_IDLE = 5'b11111;
    localparam grp_t GRP_J    = 5'b11000;
    localparam grp_t GRP_K    = 5'b10001;
    localparam grp_t GRP_T    = 5'b01101;
    localparam grp_t GRP_R    = 5'b00111;

    typedef enum logic [1:0] {FR_IDLE, FR_SSD2, FR_BODY, FR_ESD2} fr_state_e;
    typedef enum logic [1:0] {LV_ZERO = 2'b00, LV_POS = 2'b01, LV_NEG = 2'b11} lvl_e;

    typedef struct packed {
        logic       en;
        logic [3:0] nib;
    } mii_t;

    function automatic grp_t enc4b5b(input logic [3:0] n);
        grp_t g;
        case (n)
            4'h0: g = 5'b11110;
            4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;
            4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;
            4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;
            4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;
            4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;
            4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;
            4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;
            default: g = 5'b11101;
        endcase
        return g;
    endfunction

    function automatic lvl_e lvl_of_phase(input logic [1:0] ph);
        lvl_e l;
        case (ph)
            2'd1:    l = LV_POS;
            2'd3:    l = LV_NEG;
            default: l = LV_ZERO;
        endcase
        return l;
    endfunction
endpackage

// File: rtl/fxc_slot_timer.sv
`timescale 1ns/1ps
module fxc_slot_timer
    import fxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             tx_clk
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (load)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign load   = (cnt == LAST);
    assign tx_clk = (cnt < CNT_W'(TXCLK_HI));
endmodule

// File: rtl/fxc_framer.sv
`timescale 1ns/1ps
module fxc_framer
    import fxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  mii_t mii,
    output grp_t grp
);
    fr_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= FR_IDLE;
            grp <= GRP_IDLE;
        end else if (load) begin
            unique case (st)
                FR_IDLE: begin
                    if (mii.en) begin
                        grp <= GRP_J;
                        st  <= FR_SSD2;
                    end else begin
                        grp <= GRP_IDLE;
                    end
                end
                FR_SSD2: begin
                    grp <= GRP_K;
                    st  <= FR_BODY;
                end
                FR_BODY: begin
                    if (mii.en) begin
                        grp <= enc4b5b(mii.nib);
                    end else begin
                        grp <= GRP_T;
                        st  <= FR_ESD2;
                    end
                end
                FR_ESD2: begin
                    grp <= GRP_R;
                    st  <= FR_IDLE;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fxc_scrambler.sv
`timescale 1ns/1ps
module fxc_scrambler
    import fxc_pkg::*;
#(
    parameter logic [SCR_W-1:0] SEED = '1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             key,
    output logic [SCR_W-1:0] state
);
    localparam logic [SCR_W-1:0] START = (SEED == '0) ? '1 : SEED;

    assign key = state[SCR_TAP_A] ^ state[SCR_TAP_B];

    always_ff @(posedge clk) begin
        if (rst) state <= START;
        else     state <= {state[SCR_W-2:0], key};
    end
endmodule

// File: rtl/fxc_mlt3.sv
`timescale 1ns/1ps
module fxc_mlt3
    import fxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output lvl_e lvl
);
    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= 2'd0;
        else     phase <= phase + {1'b0, bit_in};
    end

    assign lvl = lvl_of_phase(phase);
endmodule

// File: rtl/fx_tx_coder.sv
`timescale 1ns/1ps
module fx_tx_coder
    import fxc_pkg::*;
#(
    parameter logic [10:0] SEED = 11'h7FF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic [3:0] txd,
    output logic       tx_clk,
    output logic [1:0] line_lvl
);
    logic [CNT_W-1:0] cnt;
    logic             load;
    grp_t             grp;
    grp_t             grp_sh;
    logic             key;
    logic [SCR_W-1:0] lfsr_q;
    logic             code_bit;
    logic             scr_bit;
    lvl_e             lvl;
    mii_t             mii;

    assign mii = '{en: tx_en, nib: txd};

    fxc_slot_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .cnt    (cnt),
        .load   (load),
        .tx_clk (tx_clk)
    );

    fxc_framer u_framer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .mii  (mii),
        .grp  (grp)
    );

    assign grp_sh   = grp << cnt;
    assign code_bit = grp_sh[GRP_W-1];

    fxc_scrambler #(.SEED(SEED)) u_scr (
        .clk   (clk),
        .rst   (rst),
        .key   (key),
        .state (lfsr_q)
    );

    assign scr_bit = code_bit ^ key;

    fxc_mlt3 u_mlt3 (
        .clk    (clk),
        .rst    (rst),
        .bit_in (scr_bit),
        .lvl    (lvl)
    );

    assign line_lvl = lvl;
endmodule

// File: rtl/fxc_checker.sv
`timescale 1ns/1ps
module fxc_checker
    import fxc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_clk,
    input logic [1:0]       line_lvl,
    input logic [CNT_W-1:0] cnt,
    input grp_t             grp,
    input logic [SCR_W-1:0] lfsr
);
    a_r1_nibble_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_clk) |=> tx_clk ##1 !tx_clk ##1 !tx_clk ##1 !tx_clk ##1 tx_clk);

    a_r2_k_after_j: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && grp == GRP_J) |-> ##5 (grp == GRP_K));

    a_r2_j_from_rest: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && grp == GRP_J) |-> ($past(grp) == GRP_IDLE || $past(grp) == GRP_R));

    a_r4_r_after_t: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && grp == GRP_T) |-> ##5 (grp == GRP_R));

    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);

    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
        line_lvl != 2'b10);

    a_r7_adjacent_step: assert property (@(posedge clk) disable iff (rst)
        (line_lvl != $past(line_lvl)) |-> (($past(line_lvl) == 2'b00) != (line_lvl == 2'b00)));
endmodule

bind fx_tx_coder fxc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_clk   (tx_clk),
    .line_lvl (line_lvl),
    .cnt      (cnt),
    .grp      (grp),
    .lfsr     (lfsr_q)
);

// File: tb/fx_tx_coder_test.sv
`timescale 1ns/1ps
module fx_tx_coder_test;
    localparam logic [10:0] SEED = 11'h5A3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_clk;
    logic [1:0] line_lvl;

    always #2.5 clk = ~clk;

    fx_tx_coder #(.SEED(SEED)) uut (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .txd      (txd),
        .tx_clk   (tx_clk),
        .line_lvl (line_lvl)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    function automatic logic [1:0] lvl_of(input logic [1:0] p);
        case (p)
            2'd1:    return 2'b01;
            2'd3:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // reference model: bit index, key stream, framing
    int unsigned edges = 0;
    logic [10:0] m_lfsr;
    logic        cur_key;
    int          mst;
    logic [4:0]  exp_grp [8];
    string       exp_tag [8];

    always @(posedge clk) begin
        if (rst) begin
            edges      = 0;
            m_lfsr     = SEED;
            mst        = 0;
            exp_grp[0] = 5'b11111;
            exp_tag[0] = "R5";
        end else begin
            cur_key = m_lfsr[10] ^ m_lfsr[8];
            m_lfsr  = {m_lfsr[9:0], cur_key};
            if (edges % 5 == 4) begin
                int nx;
                nx = int'((edges / 5 + 1) % 8);
                case (mst)
                    0: if (tx_en) begin exp_grp[nx] = 5'b11000; exp_tag[nx] = "R2"; mst = 1; end
                       else begin exp_grp[nx] = 5'b11111; exp_tag[nx] = "R5"; end
                    1: begin exp_grp[nx] = 5'b10001; exp_tag[nx] = tx_en ? "R2" : "R8"; mst = 2; end
                    2: if (tx_en) begin exp_grp[nx] = enc(txd); exp_tag[nx] = "R3"; end
                       else begin exp_grp[nx] = 5'b01101; exp_tag[nx] = "R4"; mst = 3; end
                    default: begin exp_grp[nx] = 5'b00111; exp_tag[nx] = tx_en ? "R8" : "R4"; mst = 0; end
                endcase
            end
            edges++;
        end
    end

    // line monitor: transitions -> bits -> descramble -> groups
    logic [1:0] prev_lvl;
    logic [1:0] m_ph;
    logic [4:0] acc;

    always @(negedge clk) begin
        if (rst) begin
            prev_lvl = 2'b00;
            m_ph     = 2'd0;
            acc      = 5'd0;
        end else if (edges > 0) begin
            int unsigned i;
            logic obit;
            i    = edges - 1;
            obit = (line_lvl != prev_lvl);
            prev_lvl = line_lvl;
            m_ph = m_ph + {1'b0, obit};
            chk(line_lvl == lvl_of(m_ph), "R7 mlt3 level", 32'(line_lvl), 32'(lvl_of(m_ph)));
            chk(tx_clk == (((i + 1) % 5) < 2), "R1 tx_clk phase", 32'(tx_clk), 32'(((i + 1) % 5) < 2));
            acc = {acc[3:0], obit ^ cur_key};
            if (i % 5 == 4) begin
                int s;
                s = int'((i / 5) % 8);
                chk(acc == exp_grp[s], {exp_tag[s], "/R6 code group"}, 32'(acc), 32'(exp_grp[s]));
            end
        end
    end

    task automatic slot(input logic en, input logic [3:0] d);
        do @(negedge clk); while (edges % 5 != 0);
        tx_en = en;
        txd   = d;
    endtask

    task automatic frame(input int len, input int gap);
        slot(1'b1, 4'h5);
        slot(1'b1, 4'h5);
        for (int k = 0; k < len; k++) slot(1'b1, 4'($urandom_range(0, 15)));
        for (int k = 0; k < gap; k++) slot(1'b0, 4'($urandom_range(0, 15)));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(line_lvl == 2'b00, "R7 reset level", 32'(line_lvl), 32'h0);
        chk(tx_clk == 1'b1, "R1 reset tx_clk", 32'(tx_clk), 32'h1);
        rst = 1'b0;
        repeat (3) slot(1'b0, 4'h0);
        // R8: enable for a single slot, dropped during K
        slot(1'b1, 4'h3);
        repeat (4) slot(1'b0, 4'h9);
        // R3: every table entry once
        slot(1'b1, 4'h5);
        slot(1'b1, 4'h5);
        for (int n = 0; n < 16; n++) slot(1'b1, 4'(n));
        // R8: enable low for one slot only, raised again in the R slot
        slot(1'b0, 4'h0);
        slot(1'b1, 4'hA);
        slot(1'b1, 4'h5);
        slot(1'b1, 4'h7);
        repeat (3) slot(1'b0, 4'h0);
        // random frames
        for (int f = 0; f < 60; f++) frame($urandom_range(0, 24), $urandom_range(1, 4));
        repeat (6) slot(1'b0, 4'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #990000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule